// File: doc/BRIEF.md
# Branch and Program Counter Unit

This block owns the fetch address and the return address of a small sequencer whose code is an array of 16-bit words. Once per retired instruction, qualified by `step_valid`, it takes the decoded control-transfer kind, a condition selector, the zero and carry flags and a target operand. From these it computes the address of the next instruction. That address is either the word after the current one, an absolute target, a signed offset from the word after the current one, or the saved return address. Every transfer that is taken is checked against the code length in words. A destination outside the code is a fatal fault that stops the machine.

A call saves the address of the word after the call in the single link register before it jumps. A return copies that register back into the program counter. A stop instruction halts the machine cleanly. After a stop or a fault, the program counter and the link register hold their values until reset. The two outputs `halted` and `fault` show which kind of halt it was. Decoding, flag generation and the code store sit outside the block.

Top module: `flow_pc_unit`

## Requirements
- R1: After reset, `pc` and `lr` are 0, and `halted` and `fault` are both low, so the first instruction executed is at word 0.
- R2: A step with kind 0 (none) or kind 7 sets `pc` to `pc`+1 and leaves `lr` unchanged.
- R3: A taken absolute branch (kind 1) loads `pc` with `tgt_opnd`.
- R4: A taken relative branch (kind 2) loads `pc` with `pc`+1 plus the low 8 bits of `tgt_opnd` read as a two's-complement value from -128 to +127. The upper operand bits have no effect.
- R5: `br_cond` selects when kinds 1 and 2 are taken: 0 always, 1 when Z=1, 2 when Z=0, 3 when C=1, 4 when C=0, and 5 to 7 never. A branch that is not taken sets `pc` to `pc`+1 and raises no fault.
- R6: A call (kind 3 absolute, kind 4 relative) is always taken, whatever `br_cond` says. It writes `pc`+1 into `lr` and computes the new `pc` in the same way as kind 1 or kind 2.
- R7: A return (kind 5) copies `lr` into `pc` and leaves `lr` unchanged.
- R8: A taken transfer whose destination is negative, or greater than or equal to `code_len`, sets `fault` and `halted`. In that case `pc` keeps the address of the faulting instruction and `lr` is not written.
- R9: A stop (kind 6) sets `halted` with `fault` low. `pc` stays at the address of the stop instruction.
- R10: While `halted` is high, steps are ignored: `pc`, `lr`, `halted` and `fault` hold until reset.
- R11: While `step_valid` is low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_valid | input | 1 | One instruction retires this cycle |
| br_kind | input | 3 | Transfer kind: 0 none, 1 absolute, 2 relative, 3 call absolute, 4 call relative, 5 return, 6 stop |
| br_cond | input | 3 | Condition selector for kinds 1 and 2 |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| tgt_opnd | input | ADDR_W | Absolute target, or relative offset in the low 8 bits |
| code_len | input | ADDR_W+1 | Code length in words |
| pc | output | ADDR_W | Address of the instruction being executed |
| lr | output | ADDR_W | Link register |
| halted | output | 1 | Execution stopped, by a stop or by a fault |
| fault | output | 1 | The halt was caused by an out-of-range destination |

## Verification
The main function runs through one program-like sequence. It mixes plain advances, absolute jumps, forward and backward relative jumps, and all five condition codes with each flag at both values. This shows that a taken branch and a not-taken branch land on different addresses. A relative operand with nonzero upper bits shows that only the low byte is used. A jump to `code_len`-1 and an offset of +127 probe the valid edges, while a destination equal to `code_len` and one at -1 probe the fault edges. Separate runs cover a call out of range, a stop followed by more steps, and idle cycles, to show what the block holds in each case.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [2:0] {
    XFER_NONE     = 3'd0,
    XFER_ABS      = 3'd1,
    XFER_REL      = 3'd2,
    XFER_CALL_ABS = 3'd3,
    XFER_CALL_REL = 3'd4,
    XFER_RET      = 3'd5,
    XFER_STOP     = 3'd6
  } xfer_kind_e;

  typedef enum logic [2:0] {
    COND_ALWAYS = 3'd0,
    COND_Z_SET  = 3'd1,
    COND_Z_CLR  = 3'd2,
    COND_C_SET  = 3'd3,
    COND_C_CLR  = 3'd4
  } cond_sel_e;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
  import flow_pkg::*;
(
  input  logic [2:0] cond_sel,
  input  logic       z_flag,
  input  logic       c_flag,
  output logic       cond_true
);
  always_comb begin
    case (cond_sel)
      COND_ALWAYS: cond_true = 1'b1;
      COND_Z_SET:  cond_true = z_flag;
      COND_Z_CLR:  cond_true = ~z_flag;
      COND_C_SET:  cond_true = c_flag;
      COND_C_CLR:  cond_true = ~c_flag;
      default:     cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/flow_target_calc.sv
module flow_target_calc
  import flow_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [2:0]        kind,
  input  logic              cond_true,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_lr,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [ADDR_W:0]   code_words,
  output logic [ADDR_W-1:0] dest_pc,
  output logic [ADDR_W-1:0] seq_pc,
  output logic              xfer_taken,
  output logic              link_write,
  output logic              range_err,
  output logic              stop_req
);
  // Two spare bits: one for the carry of pc+1, one for the sign.
  localparam int EW = ADDR_W + 2;

  logic [EW-1:0] adv_x;
  logic [EW-1:0] off_x;
  logic [EW-1:0] rel_x;
  logic [EW-1:0] abs_x;
  logic [EW-1:0] ret_x;
  logic [EW-1:0] dst_x;
  logic          is_call;
  logic          dst_neg;
  logic          dst_over;

  assign adv_x  = {2'b00, cur_pc} + EW'(1);
  assign off_x  = {{(EW-OFF_W){opnd[OFF_W-1]}}, opnd[OFF_W-1:0]};
  assign rel_x  = adv_x + off_x;
  assign abs_x  = {2'b00, opnd};
  assign ret_x  = {2'b00, cur_lr};
  assign seq_pc = cur_pc + ADDR_W'(1);

  always_comb begin
    xfer_taken = 1'b0;
    is_call    = 1'b0;
    stop_req   = 1'b0;
    dst_x      = adv_x;
    case (kind)
      XFER_ABS: begin
        xfer_taken = cond_true;
        dst_x      = abs_x;
      end
      XFER_REL: begin
        xfer_taken = cond_true;
        dst_x      = rel_x;
      end
      XFER_CALL_ABS: begin
        xfer_taken = 1'b1;
        is_call    = 1'b1;
        dst_x      = abs_x;
      end
      XFER_CALL_REL: begin
        xfer_taken = 1'b1;
        is_call    = 1'b1;
        dst_x      = rel_x;
      end
      XFER_RET: begin
        xfer_taken = 1'b1;
        dst_x      = ret_x;
      end
      XFER_STOP: stop_req = 1'b1;
      default: ;
    endcase
  end

  assign dst_neg    = dst_x[EW-1];
  assign dst_over   = (dst_x[EW-2:0] >= code_words);
  assign range_err  = xfer_taken & (dst_neg | dst_over);
  assign link_write = is_call & ~range_err;
  assign dest_pc    = dst_x[ADDR_W-1:0];
endmodule

// File: rtl/flow_pc_unit.sv
module flow_pc_unit #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  input  logic [2:0]        br_kind,
  input  logic [2:0]        br_cond,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] tgt_opnd,
  input  logic [ADDR_W:0]   code_len,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] lr,
  output logic              halted,
  output logic              fault
);
  // Reset synchronizer: assert asynchronously, release on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              cond_true;
  logic [ADDR_W-1:0] dest_pc;
  logic [ADDR_W-1:0] seq_pc;
  logic              xfer_taken;
  logic              link_write;
  logic              range_err;
  logic              stop_req;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] lr_q, lr_d;
  logic              halt_q, halt_d;
  logic              fault_q, fault_d;
  logic              state_en;

  flow_cond_eval u_cond (
    .cond_sel  (br_cond),
    .z_flag    (flag_z),
    .c_flag    (flag_c),
    .cond_true (cond_true)
  );

  flow_target_calc #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_calc (
    .kind       (br_kind),
    .cond_true  (cond_true),
    .cur_pc     (pc_q),
    .cur_lr     (lr_q),
    .opnd       (tgt_opnd),
    .code_words (code_len),
    .dest_pc    (dest_pc),
    .seq_pc     (seq_pc),
    .xfer_taken (xfer_taken),
    .link_write (link_write),
    .range_err  (range_err),
    .stop_req   (stop_req)
  );

  assign state_en = step_valid & ~halt_q;

  always_comb begin
    pc_d    = pc_q;
    lr_d    = lr_q;
    halt_d  = halt_q;
    fault_d = fault_q;
    if (stop_req) begin
      halt_d = 1'b1;
    end else if (range_err) begin
      halt_d  = 1'b1;
      fault_d = 1'b1;
    end else begin
      pc_d = xfer_taken ? dest_pc : seq_pc;
      if (link_write) lr_d = seq_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q    <= '0;
      lr_q    <= '0;
      halt_q  <= 1'b0;
      fault_q <= 1'b0;
    end else if (state_en) begin
      pc_q    <= pc_d;
      lr_q    <= lr_d;
      halt_q  <= halt_d;
      fault_q <= fault_d;
    end
  end

  assign pc     = pc_q;
  assign lr     = lr_q;
  assign halted = halt_q;
  assign fault  = fault_q;
endmodule

// File: rtl/flow_pc_unit_chk.sv
module flow_pc_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_valid,
  input logic [2:0]        br_kind,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] lr,
  input logic [ADDR_W:0]   code_len,
  input logic              halted,
  input logic              fault
);
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !halted && br_kind == 3'd0) |=> (pc == $past(pc) + ADDR_W'(1))); // R2

  AST_RET_FROM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !halted && br_kind == 3'd5 && {1'b0, lr} < code_len) |=> (pc == $past(lr))); // R7

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !halted && (br_kind == 3'd3 || br_kind == 3'd4)) |=> (fault || lr == $past(pc) + ADDR_W'(1))); // R6

  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted); // R8

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(lr) && $stable(fault))); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> ($stable(pc) && $stable(lr) && $stable(halted))); // R11

  AST_STOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !halted && br_kind == 3'd6) |=> (halted && !fault && $stable(pc))); // R9
endmodule

bind flow_pc_unit flow_pc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .step_valid (step_valid),
  .br_kind    (br_kind),
  .pc         (pc),
  .lr         (lr),
  .code_len   (code_len),
  .halted     (halted),
  .fault      (fault)
);

// File: tb/flow_pc_unit_tb.sv
module flow_pc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NVEC = 21;

  logic          clk;
  logic          rst_n;
  logic          step_valid;
  logic [2:0]    br_kind;
  logic [2:0]    br_cond;
  logic          flag_z;
  logic          flag_c;
  logic [AW-1:0] tgt_opnd;
  logic [AW:0]   code_len;
  logic [AW-1:0] pc;
  logic [AW-1:0] lr;
  logic          halted;
  logic          fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  flow_pc_unit #(.ADDR_W(AW), .OFF_W(8)) dut_i (
    .clk (clk), .rst_n (rst_n), .step_valid (step_valid),
    .br_kind (br_kind), .br_cond (br_cond), .flag_z (flag_z), .flag_c (flag_c),
    .tgt_opnd (tgt_opnd), .code_len (code_len),
    .pc (pc), .lr (lr), .halted (halted), .fault (fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Row layout: kind[55:53] cond[52:50] z[49] c[48] opnd[47:32] exp_pc[31:16] exp_lr[15:0]
  localparam logic [55:0] TBL [0:NVEC-1] = '{
    {3'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 16'd1,   16'd0},   // R2
    {3'd0, 3'd0, 1'b0, 1'b0, 16'h0000, 16'd2,   16'd0},   // R2
    {3'd1, 3'd0, 1'b0, 1'b0, 16'd40,   16'd40,  16'd0},   // R3
    {3'd2, 3'd0, 1'b0, 1'b0, 16'h0005, 16'd46,  16'd0},   // R4 forward
    {3'd2, 3'd0, 1'b0, 1'b0, 16'h0FF0, 16'd31,  16'd0},   // R4 -16, upper bits ignored
    {3'd1, 3'd1, 1'b0, 1'b0, 16'd90,   16'd32,  16'd0},   // R5 Z set, false
    {3'd1, 3'd1, 1'b1, 1'b0, 16'd90,   16'd90,  16'd0},   // R5 Z set, true
    {3'd2, 3'd2, 1'b1, 1'b0, 16'h0010, 16'd91,  16'd0},   // R5 Z clear, false
    {3'd2, 3'd2, 1'b0, 1'b0, 16'h0003, 16'd95,  16'd0},   // R5 Z clear, true
    {3'd1, 3'd3, 1'b0, 1'b0, 16'd10,   16'd96,  16'd0},   // R5 C set, false
    {3'd1, 3'd3, 1'b0, 1'b1, 16'd10,   16'd10,  16'd0},   // R5 C set, true
    {3'd2, 3'd4, 1'b0, 1'b1, 16'h007F, 16'd11,  16'd0},   // R5 C clear, false
    {3'd2, 3'd4, 1'b0, 1'b0, 16'h0020, 16'd44,  16'd0},   // R5 C clear, true
    {3'd3, 3'd1, 1'b0, 1'b0, 16'd70,   16'd70,  16'd45},  // R6 call abs, cond ignored
    {3'd7, 3'd0, 1'b0, 1'b0, 16'd3,    16'd71,  16'd45},  // R2 kind 7
    {3'd5, 3'd0, 1'b0, 1'b0, 16'd0,    16'd45,  16'd45},  // R7
    {3'd4, 3'd0, 1'b0, 1'b0, 16'h00FB, 16'd41,  16'd46},  // R6 call rel -5
    {3'd5, 3'd0, 1'b0, 1'b0, 16'd0,    16'd46,  16'd46},  // R7
    {3'd1, 3'd0, 1'b0, 1'b0, 16'd99,   16'd99,  16'd46},  // R8 last valid word
    {3'd2, 3'd0, 1'b0, 1'b0, 16'h009D, 16'd1,   16'd46},  // R4 -99
    {3'd1, 3'd5, 1'b1, 1'b1, 16'd7,    16'd2,   16'd46}   // R5 code 5 never
  };

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] k, input logic [2:0] cs, input logic z,
                      input logic c, input logic [AW-1:0] op);
    @(negedge clk);
    step_valid = 1'b1; br_kind = k; br_cond = cs; flag_z = z; flag_c = c; tgt_opnd = op;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_valid = 1'b0; br_kind = 3'd0; br_cond = 3'd0;
    flag_z = 1'b0; flag_c = 1'b0; tgt_opnd = '0; code_len = 17'd100;
    do_reset();
    chk("R1 pc", pc, 16'd0);
    chk("R1 lr", lr, 16'd0);
    chk("R1 halted", {15'd0, halted}, 16'd0);
    chk("R1 fault", {15'd0, fault}, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      step(TBL[i][55:53], TBL[i][52:50], TBL[i][49], TBL[i][48], TBL[i][47:32]);
      chk($sformatf("R2-table row %0d pc", i), pc, TBL[i][31:16]);
      chk($sformatf("R6 table row %0d lr", i), lr, TBL[i][15:0]);
      chk($sformatf("R5 table row %0d fault", i), {15'd0, fault}, 16'd0);
    end

    // R11: inputs present but step_valid low
    @(negedge clk);
    br_kind = 3'd1; br_cond = 3'd0; tgt_opnd = 16'd50;
    repeat (3) @(negedge clk);
    chk("R11 pc idle", pc, 16'd2);
    chk("R11 lr idle", lr, 16'd46);

    // R8: absolute target equal to code_len
    step(3'd1, 3'd0, 1'b0, 1'b0, 16'd100);
    chk("R8 fault", {15'd0, fault}, 16'd1);
    chk("R8 halted", {15'd0, halted}, 16'd1);
    chk("R8 pc kept", pc, 16'd2);
    chk("R8 lr kept", lr, 16'd46);
    // R10: further steps ignored
    step(3'd0, 3'd0, 1'b0, 1'b0, 16'd0);
    step(3'd1, 3'd0, 1'b0, 1'b0, 16'd5);
    chk("R10 pc frozen", pc, 16'd2);
    chk("R10 fault held", {15'd0, fault}, 16'd1);

    // R1 again, then R8 negative relative destination
    do_reset();
    chk("R1 pc after fault", pc, 16'd0);
    chk("R1 fault cleared", {15'd0, fault}, 16'd0);
    step(3'd2, 3'd0, 1'b0, 1'b0, 16'h00FE);
    chk("R8 negative fault", {15'd0, fault}, 16'd1);
    chk("R8 negative pc kept", pc, 16'd0);

    // R8 with call: link not written
    do_reset();
    step(3'd0, 3'd0, 1'b0, 1'b0, 16'd0);
    step(3'd3, 3'd0, 1'b0, 1'b0, 16'd100);
    chk("R8 call fault", {15'd0, fault}, 16'd1);
    chk("R8 call lr unwritten", lr, 16'd0);
    chk("R8 call pc kept", pc, 16'd1);

    // R9 stop, then R10
    do_reset();
    step(3'd0, 3'd0, 1'b0, 1'b0, 16'd0);
    step(3'd6, 3'd0, 1'b0, 1'b0, 16'd0);
    chk("R9 halted", {15'd0, halted}, 16'd1);
    chk("R9 no fault", {15'd0, fault}, 16'd0);
    chk("R9 pc at stop", pc, 16'd1);
    step(3'd1, 3'd0, 1'b0, 1'b0, 16'd5);
    chk("R10 pc after stop", pc, 16'd1);
    chk("R10 still halted", {15'd0, halted}, 16'd1);

    // R4 edges: +127 and -128
    do_reset();
    code_len = 17'd200;
    step(3'd2, 3'd0, 1'b0, 1'b0, 16'hFF7F);
    chk("R4 plus 127", pc, 16'd128);
    step(3'd2, 3'd0, 1'b0, 1'b0, 16'h0080);
    chk("R4 minus 128", pc, 16'd1);
    chk("R4 no fault", {15'd0, fault}, 16'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule